// File: doc/BRIEF.md
# Programmable Delayed Event Combiner

This block takes single-cycle event pulses from three timer compare channels and produces a delayed copy of each one. The delay is counted in low-frequency ticks: a tick-enable input marks the clock cycles that count. One 4-bit delay code applies to all channels. Codes 1 to 4 double the delay at each step. Higher codes add 16 ticks per step. Code 0 passes the event through with no tick delay.

Each channel has its own countdown. A fresh event on a channel whose countdown is still running starts that countdown again from the full delay. A 3-bit mask selects which delayed channel events are ORed into a single combined event output. The combined output is aligned in time with the delayed outputs.

Top module: `evc_delay_combiner`

## Requirements
- R1: While reset is asserted and right after it is released, `ev_dly` and `ev_comb` are low.
- R2: Codes 1, 2, 3 and 4 delay an event by 1, 2, 4 and 8 ticks. The delayed pulse appears in the clock after the tick on which the countdown reaches zero.
- R3: Codes 5 to 13 delay an event by 16, 32, 48, 64, 80, 96, 112, 128 and 144 ticks. Codes 14 and 15 also give 144 ticks.
- R4: With code 0, the delayed pulse appears in the clock right after the event is sampled, whether or not a tick is present.
- R5: A countdown advances only in cycles where `tick_en` is high. Without ticks it holds, and it produces no pulse.
- R6: An event that arrives while its channel's countdown is running reloads the full delay. The earlier pending pulse is dropped.
- R7: Each delayed output pulse lasts exactly one clock per expiry.
- R8: `ev_comb` is high in exactly the cycles where at least one `ev_dly[i]` with `comb_mask[i]` set is high. Mask bit i selects channel i, and a mask of 0 keeps `ev_comb` low.
- R9: The channels count independently. An event on one channel never changes another channel's timing.
- R10: The delay code is captured when the event arrives. Changing the code during a running countdown does not change that countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | High in cycles that count as one low-frequency tick |
| ev_in | input | 3 | Event pulse per channel, bit i = channel i |
| delay_code | input | 4 | Shared delay code |
| comb_mask | input | 3 | Channel selection for the combined event |
| ev_dly | output | 3 | Delayed event pulse per channel |
| ev_comb | output | 1 | Masked OR of the delayed events |

## Verification
The hardest case to reach is an event that lands on a channel exactly while its countdown is one tick from expiry, or in the same cycle as the expiring tick. That collision decides whether the old pulse escapes or is dropped. Random stimulus with short delay codes, sparse events and roughly half-rate ticks produces many such collisions. A per-cycle reference model, built from the requirements, checks every output. Directed runs add a restart partway through a countdown, long stretches without ticks, and a code change during a countdown.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned NUM_CH     = 3;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned DBL_LAST   = 4;   // last code of the doubling range
  localparam int unsigned STEP_TICKS = 16;
  localparam int unsigned MAX_STEPS  = 9;   // 9 * 16 = 144 ticks
  localparam int unsigned MAX_TICKS  = MAX_STEPS * STEP_TICKS;
  localparam int unsigned CNT_W      = $clog2(MAX_TICKS + 1);

  typedef logic [CNT_W-1:0] ticks_t;

  function automatic ticks_t code_to_ticks(input logic [CODE_W-1:0] code);
    int unsigned c;
    int unsigned steps;
    c = int'(code);
    if (c == 0) return '0;
    if (c <= DBL_LAST) return ticks_t'(1 << (c - 1));
    steps = c - DBL_LAST;
    if (steps > MAX_STEPS) steps = MAX_STEPS;
    return ticks_t'(steps * STEP_TICKS);
  endfunction
endpackage

// File: rtl/evc_delay_decode.sv
module evc_delay_decode
  import evc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output ticks_t            ticks
);
  always_comb begin
    ticks = code_to_ticks(code);
  end
endmodule

// File: rtl/evc_chan_timer.sv
module evc_chan_timer
  import evc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_en,
  input  logic   ev_in,
  input  ticks_t load_ticks,
  output logic   fire,
  output logic   dly_q
);
  ticks_t cnt_q, cnt_d;
  logic   busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fire   = 1'b0;
    if (ev_in) begin
      if (load_ticks == '0) begin
        fire   = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = load_ticks;
        busy_d = 1'b1;
      end
    end else if (busy_q && tick_en) begin
      if (cnt_q == ticks_t'(1)) begin
        fire   = 1'b1;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - ticks_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      dly_q  <= fire;
    end
  end

  // R5
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick_en && !ev_in |=> $stable(cnt_q) && busy_q && !dly_q);

  // R5
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_in && !(busy_q && tick_en) |=> !dly_q);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in && load_ticks != '0 |=> busy_q && cnt_q == $past(load_ticks) && !dly_q);

  // R4
  zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in && load_ticks == '0 |=> dly_q && !busy_q);
endmodule

// File: rtl/evc_combine.sv
module evc_combine
  import evc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic [NUM_CH-1:0] mask,
  output logic              comb_q
);
  logic comb_d;

  always_comb begin
    comb_d = |(fire & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comb_q <= 1'b0;
    else        comb_q <= comb_d;
  end

  // R8
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & mask) == '0 |=> !comb_q);

  // R8
  masked_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & mask) != '0 |=> comb_q);
endmodule

// File: rtl/evc_delay_combiner.sv
module evc_delay_combiner
  import evc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NUM_CH-1:0] ev_in,
  input  logic [CODE_W-1:0] delay_code,
  input  logic [NUM_CH-1:0] comb_mask,
  output logic [NUM_CH-1:0] ev_dly,
  output logic              ev_comb
);
  ticks_t            load_ticks;
  logic [NUM_CH-1:0] fire;

  evc_delay_decode u_decode (
    .code  (delay_code),
    .ticks (load_ticks)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    evc_chan_timer u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .ev_in      (ev_in[ch]),
      .load_ticks (load_ticks),
      .fire       (fire[ch]),
      .dly_q      (ev_dly[ch])
    );
  end

  evc_combine u_combine (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .mask   (comb_mask),
    .comb_q (ev_comb)
  );

  // R3
  decode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_code != '0 |-> load_ticks != '0 && load_ticks <= ticks_t'(MAX_TICKS));

  // R8
  comb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_comb |-> ev_dly != '0);
endmodule

// File: tb/evc_delay_combiner_tb.sv
module evc_delay_combiner_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [2:0] ev_in;
  logic [3:0] delay_code;
  logic [2:0] comb_mask;
  logic [2:0] ev_dly;
  logic       ev_comb;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  int  m_cnt [3];
  bit  m_busy[3];
  logic [2:0] exp_dly;
  logic       exp_comb;

  always #2 clk = ~clk;

  evc_delay_combiner u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ev_in(ev_in),
    .delay_code(delay_code), .comb_mask(comb_mask),
    .ev_dly(ev_dly), .ev_comb(ev_comb)
  );

  function automatic int ref_ticks(input int code);
    case (code)
      0: return 0;     1: return 1;     2: return 2;     3: return 4;
      4: return 8;     5: return 16;    6: return 32;    7: return 48;
      8: return 64;    9: return 80;    10: return 96;   11: return 112;
      12: return 128;  default: return 144;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock: drive inputs, advance the reference model, then compare
  task automatic step(input logic [2:0] ev, input logic tk, input logic [3:0] code,
                      input logic [2:0] msk, input string req);
    ev_in = ev; tick_en = tk; delay_code = code; comb_mask = msk;
    for (int i = 0; i < 3; i++) begin
      exp_dly[i] = 1'b0;
      if (ev[i]) begin
        if (ref_ticks(int'(code)) == 0) begin
          exp_dly[i] = 1'b1; m_busy[i] = 1'b0; m_cnt[i] = 0;
        end else begin
          m_cnt[i] = ref_ticks(int'(code)); m_busy[i] = 1'b1;
        end
      end else if (m_busy[i] && tk) begin
        if (m_cnt[i] == 1) begin
          exp_dly[i] = 1'b1; m_busy[i] = 1'b0; m_cnt[i] = 0;
        end else m_cnt[i]--;
      end
    end
    exp_comb = |(exp_dly & msk);
    @(posedge clk); #1;
    cyc++;
    check(ev_dly == exp_dly && ev_comb == exp_comb, req,
          int'({ev_dly, ev_comb}), int'({exp_dly, exp_comb}));
  endtask

  task automatic flush();
    for (int i = 0; i < 200; i++) step(3'b000, 1'b1, 4'd0, 3'b111, "R9");
  endtask

  // event on channel ch with ticks every cycle; return cycles until the pulse
  task automatic measure(input int ch, input logic [3:0] code, output int lat);
    logic [2:0] e;
    e = 3'b001 << ch;
    lat = -1;
    step(e, 1'b1, code, 3'b111, "R2");
    if (ev_dly[ch]) lat = 0;
    for (int i = 1; i <= 200 && lat < 0; i++) begin
      step(3'b000, 1'b1, code, 3'b111, "R3");
      if (ev_dly[ch]) lat = i;
    end
    step(3'b000, 1'b1, code, 3'b111, "R7");
    check(ev_dly[ch] == 1'b0, "R7 pulse width", int'(ev_dly[ch]), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int lat;
    process::self().srandom(32'h5eed_1234);
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_busy[i] = 1'b0; end
    rst_n = 1'b0; tick_en = 1'b0; ev_in = '0; delay_code = '0; comb_mask = '0;
    repeat (3) @(posedge clk);
    #1;
    check(ev_dly == 3'b000 && ev_comb == 1'b0, "R1 in reset", int'({ev_dly, ev_comb}), 0);
    rst_n = 1'b1;
    step(3'b000, 1'b0, 4'd0, 3'b111, "R1");
    check(ev_dly == 3'b000 && ev_comb == 1'b0, "R1 after release", int'({ev_dly, ev_comb}), 0);

    // R2 R3 R4: delay of every code, ticks every cycle
    for (int c = 0; c < 16; c++) begin
      measure(c % 3, 4'(c), lat);
      check(lat == ref_ticks(c), c <= 4 ? "R2/R4 code latency" : "R3 code latency",
            lat, ref_ticks(c));
    end

    // R4: code 0 without any tick
    step(3'b010, 1'b0, 4'd0, 3'b010, "R4");
    check(ev_dly == 3'b010 && ev_comb, "R4 no-tick passthrough", int'(ev_dly), 2);

    // R5: countdown holds without ticks
    step(3'b001, 1'b0, 4'd2, 3'b111, "R5");
    for (int i = 0; i < 6; i++) step(3'b000, 1'b0, 4'd2, 3'b111, "R5");
    check(ev_dly[0] == 1'b0, "R5 held without tick", int'(ev_dly[0]), 0);
    step(3'b000, 1'b1, 4'd2, 3'b111, "R5");
    check(ev_dly[0] == 1'b0, "R5 one tick of two", int'(ev_dly[0]), 0);
    step(3'b000, 1'b1, 4'd2, 3'b111, "R5");
    check(ev_dly[0] == 1'b1, "R5 second tick expires", int'(ev_dly[0]), 1);

    // R6: restart midway, code 3 = 4 ticks
    step(3'b010, 1'b1, 4'd3, 3'b111, "R6");
    step(3'b000, 1'b1, 4'd3, 3'b111, "R6");
    step(3'b000, 1'b1, 4'd3, 3'b111, "R6");
    step(3'b010, 1'b1, 4'd3, 3'b111, "R6");
    lat = -1;
    for (int i = 1; i <= 8 && lat < 0; i++) begin
      step(3'b000, 1'b1, 4'd3, 3'b111, "R6");
      if (ev_dly[1]) lat = i;
    end
    check(lat == 4, "R6 restart latency", lat, 4);

    // R10: code change during countdown
    step(3'b100, 1'b1, 4'd5, 3'b111, "R10");
    lat = -1;
    for (int i = 1; i <= 40 && lat < 0; i++) begin
      step(3'b000, 1'b1, 4'd1, 3'b111, "R10");
      if (ev_dly[2]) lat = i;
    end
    check(lat == 16, "R10 captured code", lat, 16);

    // R8: every mask against single and all-channel events
    for (int m = 0; m < 8; m++) begin
      step(3'b111, 1'b0, 4'd0, 3'(m), "R8");
      check(ev_comb == (m != 0), "R8 all channels", int'(ev_comb), int'(m != 0));
      for (int c = 0; c < 3; c++) begin
        step(3'b001 << c, 1'b0, 4'd0, 3'(m), "R8");
        check(ev_comb == m[c], "R8 single channel", int'(ev_comb), int'(m[c]));
      end
    end

    // R9 and collisions: random traffic against the reference model
    flush();
    begin
      logic [3:0] code;
      logic [2:0] msk;
      code = 4'd2; msk = 3'b101;
      for (int i = 0; i < 6000; i++) begin
        logic [2:0] ev;
        if ($urandom_range(0, 63) == 0)
          code = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(5, 15))
                                             : 4'($urandom_range(0, 4));
        if ($urandom_range(0, 31) == 0) msk = 3'($urandom_range(0, 7));
        for (int c = 0; c < 3; c++) ev[c] = ($urandom_range(0, 11) == 0);
        step(ev, 1'($urandom_range(0, 1)), code, msk, "R9");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule